// File: doc/BRIEF.md
# Software-Refilled Fully Associative Address Translation Buffer

This block caches recent virtual-to-physical page mappings. Each access presents a virtual page number and page offset. All stored tags are compared at once, and in the same cycle the block either reports a hit with the physical page number and the entry's flags, or it reports a miss. A miss is visible before the clock edge that ends the access, so exception handling can start on the next cycle. At that edge the full faulting virtual address is latched for the handler.

The block never fills itself. A handler refills it through a small register file:

- A high register holds a virtual page number.
- A low register holds a physical page number, its flags and a valid bit.
- An index register names a slot. That slot is used for indexed reads and indexed writes.
- A free-running down-counter names a slot for random replacement. It never descends below a programmable wired floor, so slots under the floor keep their mappings.

Hits update the stored usage flags: a hit marks the entry referenced, and a store hit also marks it dirty.

Top module: `tlb_swfill`

## Requirements
- R1: When `acc_valid` is high and a valid entry's tag equals `acc_vpn`, `hit` is high in that same cycle. `hit_ppn`, `hit_dirty`, `hit_refd` and `hit_perm` then show that entry's stored values.
- R2: When `acc_valid` is high and no valid entry matches, `miss` is high in that same cycle. `hit` and `miss` are never high together, and both are low while `acc_valid` is low.
- R3: At the edge that ends a missed access, `bad_vaddr` loads `{acc_vpn, acc_off}`. In every other cycle it holds its value.
- R4: The low register packs an entry as follows: bit 0 is valid, bits PERM_W..1 are the permission field, bit PERM_W+1 is referenced, bit PERM_W+2 is dirty, and the bits above hold the physical page number.
- R5: `sw_cmd` = 2'b10 copies the high and low registers into the slot named by `idx_q` at the next edge.
- R6: `sw_cmd` = 2'b01 loads the high and low registers from the slot named by `idx_q` at the next edge. This read takes priority over `hi_we` and `lo_we`. `sw_cmd` = 2'b00 does nothing.
- R7: `sw_cmd` = 2'b11 copies the high and low registers into the slot named by `rand_q` in that cycle.
- R8: `rand_q` is ENTRIES-1 after reset and after any write of the wired floor. Otherwise, on each edge it moves from a value above the floor to that value minus one, and from a value at or below the floor back to ENTRIES-1.
- R9: If several valid entries match, the lowest-numbered one supplies the outputs and `multi_hit` is high.
- R10: A hit sets the referenced bit of the winning entry. A hit with `acc_write` high also sets its dirty bit. A software write to the same slot in that cycle takes precedence over both.
- R11: Reset invalidates every entry, clears `idx_q` and the wired floor, and sets `rand_q` to ENTRIES-1.
- R12: An entry whose valid bit is clear never matches, whatever its tag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access present this cycle |
| acc_write | input | 1 | Access is a store |
| acc_vpn | input | VPN_W | Virtual page number of the access |
| acc_off | input | OFF_W | Page offset of the access |
| hit | output | 1 | Translation found |
| miss | output | 1 | No translation, exception request |
| multi_hit | output | 1 | More than one entry matched |
| hit_ppn | output | PPN_W | Physical page number on hit |
| hit_dirty | output | 1 | Dirty flag of hit entry |
| hit_refd | output | 1 | Referenced flag of hit entry |
| hit_perm | output | PERM_W | Permission field of hit entry |
| bad_vaddr | output | VPN_W+OFF_W | Last faulting virtual address |
| hi_we | input | 1 | Load high register |
| hi_wdata | input | VPN_W | High register write data |
| lo_we | input | 1 | Load low register |
| lo_wdata | input | PPN_W+PERM_W+3 | Low register write data |
| idx_we | input | 1 | Load index register |
| idx_wdata | input | log2(ENTRIES) | Index register write data |
| wired_we | input | 1 | Load wired floor |
| wired_wdata | input | log2(ENTRIES) | Wired floor write data |
| sw_cmd | input | 2 | 00 none, 01 read, 10 indexed write, 11 random write |
| hi_q | output | VPN_W | High register |
| lo_q | output | PPN_W+PERM_W+3 | Low register |
| idx_q | output | log2(ENTRIES) | Index register |
| rand_q | output | log2(ENTRIES) | Random replacement slot |

## Verification
All sixteen slots are filled with distinct tags and then looked up one by one. This shows that every comparator and every output mux lane is reached, and readback afterwards separates loads from stores through their dirty bits. Separate patterns cover the remaining cases:

- A tag present nowhere, which shows the miss path and the latching of the faulting address.
- A duplicate tag, which shows lowest-slot priority.
- An invalidated slot, which shows that the valid bit gates matching.

The random counter is swept over several full periods with the floor at zero and at four, and every step is compared against the decrement-and-wrap arithmetic. A burst of random writes then shows that slots below the floor keep their mappings.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // Software command encoding on sw_cmd
   typedef enum logic [1:0] {
      SW_NOP     = 2'b00,
      SW_READ    = 2'b01,
      SW_WR_IDX  = 2'b10,
      SW_WR_RAND = 2'b11
   } sw_cmd_e;

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [ENTRIES-1:0]            valid_vec,
   input  logic [ENTRIES-1:0][VPN_W-1:0] tags,
   input  logic [VPN_W-1:0]              key,
   output logic [ENTRIES-1:0]            match_vec,
   output logic                          any_match,
   output logic                          multi_match,
   output logic [IDX_W-1:0]              first_idx
);

   // One comparator per slot, all working in parallel
   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign match_vec[g] = valid_vec[g] && (tags[g] == key);
   end

   assign any_match   = |match_vec;
   assign multi_match = ($countones(match_vec) > 1);

   // Lowest-numbered match wins: scan downward so the last hit written is the lowest
   always_comb begin
      first_idx = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (match_vec[i]) first_idx = IDX_W'(i);
      end
   end

   always_comb begin
      if (any_match) begin
         p_first_is_match_r9 : assert (match_vec[first_idx])
            else $error("winner slot does not match");
      end
      if (multi_match) begin
         p_multi_needs_any_r9 : assert (any_match)
            else $error("multi-match without match");
      end
   end

endmodule

// File: rtl/tlb_rand_ctr.sv
module tlb_rand_ctr #(
   parameter int ENTRIES = 16,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wired_we,
   input  logic [IDX_W-1:0] wired_wdata,
   output logic [IDX_W-1:0] wired_q,
   output logic [IDX_W-1:0] rand_q
);

   localparam logic [IDX_W-1:0] TOP = IDX_W'(ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wired_q <= '0;
         rand_q  <= TOP;
      end else if (wired_we) begin
         wired_q <= wired_wdata;
         rand_q  <= TOP;
      end else if (rand_q <= wired_q) begin
         rand_q  <= TOP;
      end else begin
         rand_q  <= rand_q - 1'b1;
      end
   end

   p_rand_step_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (!wired_we && rand_q > wired_q) |=> rand_q == $past(rand_q) - 1'b1)
      else $error("random counter failed to decrement");

   p_rand_wrap_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (wired_we || rand_q <= wired_q) |=> rand_q == TOP)
      else $error("random counter failed to wrap");

endmodule

// File: rtl/tlb_swfill.sv
module tlb_swfill
   import tlb_pkg::*;
#(
   parameter int ENTRIES = 16,
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 18,
   parameter int OFF_W   = 12,
   parameter int PERM_W  = 2,
   localparam int IDX_W  = $clog2(ENTRIES),
   localparam int LO_W   = PPN_W + PERM_W + 3,
   localparam int BAD_W  = VPN_W + OFF_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_valid,
   input  logic              acc_write,
   input  logic [VPN_W-1:0]  acc_vpn,
   input  logic [OFF_W-1:0]  acc_off,
   output logic              hit,
   output logic              miss,
   output logic              multi_hit,
   output logic [PPN_W-1:0]  hit_ppn,
   output logic              hit_dirty,
   output logic              hit_refd,
   output logic [PERM_W-1:0] hit_perm,
   output logic [BAD_W-1:0]  bad_vaddr,
   input  logic              hi_we,
   input  logic [VPN_W-1:0]  hi_wdata,
   input  logic              lo_we,
   input  logic [LO_W-1:0]   lo_wdata,
   input  logic              idx_we,
   input  logic [IDX_W-1:0]  idx_wdata,
   input  logic              wired_we,
   input  logic [IDX_W-1:0]  wired_wdata,
   input  logic [1:0]        sw_cmd,
   output logic [VPN_W-1:0]  hi_q,
   output logic [LO_W-1:0]   lo_q,
   output logic [IDX_W-1:0]  idx_q,
   output logic [IDX_W-1:0]  rand_q
);

   if (ENTRIES < 2 || (1 << IDX_W) != ENTRIES) begin : g_bad_entries
      $error("ENTRIES must be a power of two of at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || PERM_W < 1 || OFF_W < 1) begin : g_bad_width
      $error("field widths must be positive");
   end

   // Bit positions inside the low register
   localparam int P_VALID = 0;
   localparam int P_PERM  = 1;
   localparam int P_REFD  = PERM_W + 1;
   localparam int P_DIRTY = PERM_W + 2;
   localparam int P_PPN   = PERM_W + 3;

   // Entry storage
   logic [ENTRIES-1:0]             e_valid;
   logic [ENTRIES-1:0][VPN_W-1:0]  e_vpn;
   logic [ENTRIES-1:0][PPN_W-1:0]  e_ppn;
   logic [ENTRIES-1:0][PERM_W-1:0] e_perm;
   logic [ENTRIES-1:0]             e_dirty;
   logic [ENTRIES-1:0]             e_refd;

   sw_cmd_e          cmd;
   logic             sw_wr;
   logic [IDX_W-1:0] sw_slot;
   logic [IDX_W-1:0] wired_q;

   logic [ENTRIES-1:0] m_vec;
   logic               m_any;
   logic               m_multi;
   logic [IDX_W-1:0]   hit_idx;

   assign cmd     = sw_cmd_e'(sw_cmd);
   assign sw_wr   = (cmd == SW_WR_IDX) || (cmd == SW_WR_RAND);
   assign sw_slot = (cmd == SW_WR_RAND) ? rand_q : idx_q;

   tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W)) u_match (
      .valid_vec   (e_valid),
      .tags        (e_vpn),
      .key         (acc_vpn),
      .match_vec   (m_vec),
      .any_match   (m_any),
      .multi_match (m_multi),
      .first_idx   (hit_idx)
   );

   tlb_rand_ctr #(.ENTRIES(ENTRIES)) u_rand (
      .clk         (clk),
      .rst_n       (rst_n),
      .wired_we    (wired_we),
      .wired_wdata (wired_wdata),
      .wired_q     (wired_q),
      .rand_q      (rand_q)
   );

   // Same-cycle lookup results
   assign hit       = acc_valid && m_any;
   assign miss      = acc_valid && !m_any;
   assign multi_hit = acc_valid && m_multi;
   assign hit_ppn   = e_ppn[hit_idx];
   assign hit_dirty = e_dirty[hit_idx];
   assign hit_refd  = e_refd[hit_idx];
   assign hit_perm  = e_perm[hit_idx];

   // Entry array: usage flag updates, then software writes override
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         e_valid <= '0;
         e_vpn   <= '0;
         e_ppn   <= '0;
         e_perm  <= '0;
         e_dirty <= '0;
         e_refd  <= '0;
      end else begin
         if (hit) begin
            e_refd[hit_idx] <= 1'b1;
            if (acc_write) e_dirty[hit_idx] <= 1'b1;
         end
         if (sw_wr) begin
            e_vpn[sw_slot]   <= hi_q;
            e_valid[sw_slot] <= lo_q[P_VALID];
            e_perm[sw_slot]  <= lo_q[P_PERM +: PERM_W];
            e_refd[sw_slot]  <= lo_q[P_REFD];
            e_dirty[sw_slot] <= lo_q[P_DIRTY];
            e_ppn[sw_slot]   <= lo_q[P_PPN +: PPN_W];
         end
      end
   end

   // Software-visible registers
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         hi_q  <= '0;
         lo_q  <= '0;
         idx_q <= '0;
      end else begin
         if (idx_we) idx_q <= idx_wdata;
         if (cmd == SW_READ) begin
            hi_q <= e_vpn[idx_q];
            lo_q <= {e_ppn[idx_q], e_dirty[idx_q], e_refd[idx_q],
                     e_perm[idx_q], e_valid[idx_q]};
         end else begin
            if (hi_we) hi_q <= hi_wdata;
            if (lo_we) lo_q <= lo_wdata;
         end
      end
   end

   // Faulting address capture
   always_ff @(posedge clk) begin
      if (!rst_n)    bad_vaddr <= '0;
      else if (miss) bad_vaddr <= {acc_vpn, acc_off};
   end

   p_hit_miss_excl_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      !(hit && miss))
      else $error("hit and miss together");

   p_bad_capture_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      miss |=> bad_vaddr == $past({acc_vpn, acc_off}))
      else $error("faulting address not captured");

   p_bad_hold_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      !miss |=> $stable(bad_vaddr))
      else $error("faulting address changed without a miss");

   p_wr_idx_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == SW_WR_IDX) |=> e_vpn[$past(idx_q)] == $past(hi_q))
      else $error("indexed write lost");

   p_ref_set_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && !sw_wr) |=> e_refd[$past(hit_idx)])
      else $error("reference bit not set on hit");

   p_dirty_set_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (hit && acc_write && !sw_wr) |=> e_dirty[$past(hit_idx)])
      else $error("dirty bit not set on store hit");

endmodule

// File: tb/test_tlb_swfill.sv
`timescale 1ns/1ps
module test_tlb_swfill;

   localparam int ENTRIES = 16;
   localparam int VPN_W   = 20;
   localparam int PPN_W   = 18;
   localparam int OFF_W   = 12;
   localparam int PERM_W  = 2;
   localparam int IDX_W   = 4;
   localparam int LO_W    = PPN_W + PERM_W + 3;
   localparam int BAD_W   = VPN_W + OFF_W;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0;
   logic [VPN_W-1:0] acc_vpn = '0;
   logic [OFF_W-1:0] acc_off = '0;
   logic hit, miss, multi_hit, hit_dirty, hit_refd;
   logic [PPN_W-1:0] hit_ppn;
   logic [PERM_W-1:0] hit_perm;
   logic [BAD_W-1:0] bad_vaddr;
   logic hi_we = 1'b0, lo_we = 1'b0, idx_we = 1'b0, wired_we = 1'b0;
   logic [VPN_W-1:0] hi_wdata = '0;
   logic [LO_W-1:0] lo_wdata = '0;
   logic [IDX_W-1:0] idx_wdata = '0, wired_wdata = '0;
   logic [1:0] sw_cmd = 2'b00;
   logic [VPN_W-1:0] hi_q;
   logic [LO_W-1:0] lo_q;
   logic [IDX_W-1:0] idx_q, rand_q;

   int n_vec = 0;
   int n_bad = 0;
   int wired = 0;

   always #2.5 clk = ~clk;

   tlb_swfill i_tlb_swfill (
      .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .acc_write(acc_write),
      .acc_vpn(acc_vpn), .acc_off(acc_off), .hit(hit), .miss(miss),
      .multi_hit(multi_hit), .hit_ppn(hit_ppn), .hit_dirty(hit_dirty),
      .hit_refd(hit_refd), .hit_perm(hit_perm), .bad_vaddr(bad_vaddr),
      .hi_we(hi_we), .hi_wdata(hi_wdata), .lo_we(lo_we), .lo_wdata(lo_wdata),
      .idx_we(idx_we), .idx_wdata(idx_wdata), .wired_we(wired_we),
      .wired_wdata(wired_wdata), .sw_cmd(sw_cmd), .hi_q(hi_q), .lo_q(lo_q),
      .idx_q(idx_q), .rand_q(rand_q)
   );

   function automatic logic [VPN_W-1:0] vp(input int i);
      return VPN_W'(32'h01000 + i * 32'h123);
   endfunction
   function automatic logic [PPN_W-1:0] pp(input int i);
      return PPN_W'(i * 37 + 5);
   endfunction
   // R4 packing: {ppn, dirty, refd, perm, valid}
   function automatic logic [LO_W-1:0] mk_lo(input logic v, input logic [PERM_W-1:0] pm,
                                             input logic rf, input logic dt,
                                             input logic [PPN_W-1:0] pn);
      return {pn, dt, rf, pm, v};
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr_idx(input int slot, input logic [VPN_W-1:0] v, input logic [LO_W-1:0] lo);
      @(negedge clk);
      hi_we = 1'b1; hi_wdata = v; lo_we = 1'b1; lo_wdata = lo;
      idx_we = 1'b1; idx_wdata = IDX_W'(slot);
      @(negedge clk);
      hi_we = 1'b0; lo_we = 1'b0; idx_we = 1'b0; sw_cmd = 2'b10;
      @(negedge clk);
      sw_cmd = 2'b00;
   endtask

   task automatic wr_rand(input logic [VPN_W-1:0] v, input logic [LO_W-1:0] lo, output int slot);
      @(negedge clk);
      hi_we = 1'b1; hi_wdata = v; lo_we = 1'b1; lo_wdata = lo;
      @(negedge clk);
      hi_we = 1'b0; lo_we = 1'b0; sw_cmd = 2'b11;
      #1 slot = int'(rand_q);
      @(negedge clk);
      sw_cmd = 2'b00;
   endtask

   task automatic rd_idx(input int slot);
      @(negedge clk);
      idx_we = 1'b1; idx_wdata = IDX_W'(slot);
      @(negedge clk);
      idx_we = 1'b0; sw_cmd = 2'b01;
      @(negedge clk);
      sw_cmd = 2'b00;
      #1;
   endtask

   task automatic look(input logic [VPN_W-1:0] v, input logic [OFF_W-1:0] o, input logic w);
      @(negedge clk);
      acc_valid = 1'b1; acc_vpn = v; acc_off = o; acc_write = w;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0;
      #1;
   endtask

   task automatic rand_sweep(input int cycles, input string req);
      int prev;
      @(negedge clk);
      #1 prev = int'(rand_q);
      for (int k = 0; k < cycles; k++) begin
         int exp;
         exp = (prev <= wired) ? ENTRIES - 1 : prev - 1;
         @(negedge clk);
         #1 chk(req, rand_q, exp);
         chk(req, (int'(rand_q) >= wired) ? 1 : 0, 1);
         prev = int'(rand_q);
      end
   endtask

   initial begin
      #(5.0 * 150000);
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      int slots[12];
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      chk("R11 rand", rand_q, ENTRIES - 1);
      chk("R11 idx", idx_q, 0);
      look('0, '0, 1'b0);
      chk("R11 no valid entry", hit, 0);
      chk("R2 miss after reset", miss, 1);
      idle();
      chk("R2 idle no miss", miss, 0);
      chk("R2 idle no hit", hit, 0);

      // R8 counter sweep with floor 0
      rand_sweep(40, "R8 floor0");

      // R5 fill every slot
      for (int i = 0; i < ENTRIES; i++)
         wr_idx(i, vp(i), mk_lo(1'b1, PERM_W'(i % 4), 1'b0, 1'b0, pp(i)));

      // R1/R4 lookup sweep
      for (int i = 0; i < ENTRIES; i++) begin
         look(vp(i), OFF_W'(i), 1'b0);
         chk("R1 hit", hit, 1);
         chk("R1 ppn", hit_ppn, pp(i));
         chk("R4 perm", hit_perm, i % 4);
         chk("R1 dirty clear", hit_dirty, 0);
         chk("R1 refd clear", hit_refd, 0);
         chk("R9 single", multi_hit, 0);
      end
      idle();

      // R2/R3 miss and capture
      look(20'hFFFFF, 12'hABC, 1'b0);
      chk("R2 miss", miss, 1);
      chk("R2 no hit", hit, 0);
      idle();
      chk("R3 capture", bad_vaddr, {20'hFFFFF, 12'hABC});
      look(vp(2), 12'h123, 1'b0);
      idle();
      chk("R3 hold on hit", bad_vaddr, {20'hFFFFF, 12'hABC});

      // R10 store hit
      look(vp(3), 12'h0, 1'b1);
      idle();
      look(vp(3), 12'h0, 1'b0);
      chk("R10 dirty on lookup", hit_dirty, 1);
      chk("R10 refd on lookup", hit_refd, 1);
      idle();
      rd_idx(3);
      chk("R6 R10 readback 3", lo_q, mk_lo(1'b1, 2'd3, 1'b1, 1'b1, pp(3)));
      chk("R6 hi readback 3", hi_q, vp(3));
      rd_idx(5);
      chk("R6 R10 readback 5", lo_q, mk_lo(1'b1, 2'd1, 1'b1, 1'b0, pp(5)));
      chk("R6 hi readback 5", hi_q, vp(5));

      // R9 duplicate tag: slot 9 takes slot 4's tag
      wr_idx(9, vp(4), mk_lo(1'b1, 2'd0, 1'b0, 1'b0, 18'h3FFFF));
      look(vp(4), '0, 1'b0);
      chk("R9 hit", hit, 1);
      chk("R9 multi", multi_hit, 1);
      chk("R9 lowest wins", hit_ppn, pp(4));
      look(vp(9), '0, 1'b0);
      chk("R2 remapped miss", miss, 1);
      idle();

      // R12 invalid slot
      wr_idx(6, vp(6), mk_lo(1'b0, 2'd2, 1'b0, 1'b0, pp(6)));
      look(vp(6), '0, 1'b0);
      chk("R12 invalid no hit", hit, 0);
      chk("R12 invalid miss", miss, 1);
      idle();

      // R8 wired floor 4
      @(negedge clk);
      wired_we = 1'b1; wired_wdata = 4'd4;
      @(negedge clk);
      wired_we = 1'b0; wired = 4;
      #1 chk("R8 wired write top", rand_q, ENTRIES - 1);
      rand_sweep(40, "R8 floor4");

      // R7 random writes
      for (int k = 0; k < 12; k++) begin
         wr_rand(VPN_W'(32'hC0000 + k), mk_lo(1'b1, 2'd1, 1'b0, 1'b0, PPN_W'(32'h20000 + k)), slots[k]);
         chk("R7 slot above floor", (slots[k] >= 4) ? 1 : 0, 1);
      end
      look(VPN_W'(32'hC0000 + 11), '0, 1'b0);
      chk("R7 random entry hit", hit, 1);
      chk("R7 random entry ppn", hit_ppn, 32'h20000 + 11);
      idle();
      rd_idx(slots[11]);
      chk("R7 slot readback", hi_q, 32'hC0000 + 11);
      for (int i = 0; i < 4; i++) begin
         look(vp(i), '0, 1'b0);
         chk("R8 wired slot kept", hit_ppn, pp(i));
      end
      idle();

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule